// File: doc/BRIEF.md
# Supply-Low and Watchdog Reset Generator

This block produces the active-high chip reset from three sources: the power-on reset pin, a digital supply-low flag delivered by an external voltage comparator, and an internal watchdog timer. Reset goes high at once whenever power-on reset or supply-low is present. After either one goes away, reset is held for a fixed stretch of crystal clock cycles so that the oscillator has settled before the chip leaves reset.

The watchdog counts quarter-second units. Each unit is a parameterised number of clock cycles, so a small value can be used in simulation. Software writes a small control word with three parts: a 3-bit interval field, an enable bit and a restart bit. Once the timer is enabled, it forces a reset of the same stretched length if software does not restart it within the selected interval. The enable bit survives the watchdog's own reset. Only power-on reset or supply-low clears it.

Top module: `supply_wdt_reset`

## Requirements
- R1: `rst_o` is high in every cycle in which `rst_ni` is low or `supply_low_i` is high, with no wait for a clock edge.
- R2: Once `supply_low_i` goes low, `rst_o` stays high for exactly HOLD_CYC (144) further rising clock edges and then releases on a clock edge.
- R3: After `rst_ni` rises, `rst_o` stays high for HOLD_CYC rising edges. In that state the watchdog is off and `cfg_rdata_o` reads 0.
- R4: The control word puts the restart bit at bit 4, the enable bit at bit 3 and the interval field at bits 2:0. The interval N equals the field value for 1 to 7, and a field value of 0 gives N = 8. Take the last rising edge at which the write took effect, or at which reset released, and call it the start edge. `rst_o` rises after the edge that lies N*TICK_CYC rising edges after the start edge.
- R5: A watchdog overflow holds `rst_o` high for exactly HOLD_CYC cycles.
- R6: The enable bit can only be set by software. Writing 0 to it has no effect, and it stays set through a watchdog reset. A supply-low event clears both it and the interval field.
- R7: Writing the restart bit sets the count back to zero. It always reads as 0. When the restart write lands on the same edge as an overflow, the restart wins and no reset occurs.
- R8: Writes are ignored in every cycle in which `rst_o` is high.
- R9: While the enable bit is clear, the watchdog never asserts reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Crystal clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| supply_low_i | input | 1 | Supply below threshold, from the comparator |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_wdata_i | input | 5 | Control word: restart[4], enable[3], interval[2:0] |
| cfg_rdata_o | output | 5 | Control word read-back, restart reads 0 |
| rst_o | output | 1 | Chip reset, active high |

## Verification
A software restart and a watchdog overflow can fall in the same cycle. The bench enables the timer at the shortest interval and then times a restart write so that it takes effect on exactly the edge where the final tick would overflow. The design passes only if no reset appears on that edge and the next overflow comes one full interval after the restart. The bench also sweeps all eight interval codes, both from a fresh enable and again after each watchdog reset.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;
  localparam int SEL_W   = 3;
  localparam int CFG_W   = 5;
  localparam int CLR_BIT = 4;
  localparam int EN_BIT  = 3;
  localparam int UNIT_W  = 4;

  // interval code 0 selects the longest interval
  function automatic logic [UNIT_W-1:0] sel_to_units(logic [SEL_W-1:0] s);
    return (s == '0) ? UNIT_W'(8) : UNIT_W'(s);
  endfunction
endpackage

// File: rtl/rst_hold_ctr.sv
module rst_hold_ctr #(
  parameter int HOLD_CYC = 144
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvr_i,
  input  logic ovf_i,
  output logic busy_o
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= HOLD_V;
    else if (lvr_i || ovf_i)  cnt_q <= HOLD_V;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  p_lvr_reload_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvr_i |=> (cnt_q == HOLD_V));
  p_ovf_stretch_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> (busy_o && cnt_q == HOLD_V));
endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int TICK_CYC = 3_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int PW = $clog2(TICK_CYC + 1);
  localparam logic [PW-1:0] LAST = PW'(TICK_CYC - 1);

  logic [PW-1:0] pre_q;
  logic          wrap;

  assign wrap   = (pre_q == LAST);
  assign tick_o = run_i && !clr_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               pre_q <= '0;
    else if (!run_i || clr_i)  pre_q <= '0;
    else if (wrap)             pre_q <= '0;
    else                       pre_q <= pre_q + 1'b1;
  end

  p_pre_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_q <= LAST);
  p_idle_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (pre_q == '0));
endmodule

// File: rtl/wdt_interval.sv
module wdt_interval
  import rstgen_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             ovf_o
);
  logic [UNIT_W-1:0] unit_q;
  logic [UNIT_W-1:0] limit;

  assign limit = sel_to_units(sel_i) - 1'b1;
  // >= keeps a shortened interval from running past its limit
  assign ovf_o = tick_i && (unit_q >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               unit_q <= '0;
    else if (!run_i || clr_i)  unit_q <= '0;
    else if (ovf_o)            unit_q <= '0;
    else if (tick_i)           unit_q <= unit_q + 1'b1;
  end

  p_units_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unit_q <= UNIT_W'(7));
  p_clr_no_ovf_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> !ovf_o);
endmodule

// File: rtl/supply_wdt_reset.sv
module supply_wdt_reset
  import rstgen_pkg::*;
#(
  parameter int HOLD_CYC = 144,
  parameter int TICK_CYC = 3_000_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             supply_low_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [CFG_W-1:0] cfg_rdata_o,
  output logic             rst_o
);
  logic             wen_q;
  logic [SEL_W-1:0] sel_q;
  logic             busy, wr_ok, clr, run, tick, ovf;

  assign rst_o = !rst_ni || supply_low_i || busy;
  assign wr_ok = cfg_we_i && !rst_o;
  assign clr   = wr_ok && cfg_wdata_i[CLR_BIT];
  assign run   = wen_q && !rst_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wen_q <= 1'b0;
      sel_q <= '0;
    end else if (supply_low_i) begin
      wen_q <= 1'b0;
      sel_q <= '0;
    end else if (wr_ok) begin
      if (cfg_wdata_i[EN_BIT]) wen_q <= 1'b1;
      sel_q <= cfg_wdata_i[SEL_W-1:0];
    end
  end

  assign cfg_rdata_o = {1'b0, wen_q, sel_q};

  rst_hold_ctr #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvr_i (supply_low_i),
    .ovf_i (ovf),
    .busy_o(busy)
  );

  wdt_prescale #(.TICK_CYC(TICK_CYC)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .clr_i (clr),
    .tick_o(tick)
  );

  wdt_interval u_int (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .clr_i (clr),
    .tick_i(tick),
    .sel_i (sel_q),
    .ovf_o (ovf)
  );

  p_lvr_forces_rst_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    supply_low_i |-> rst_o);
  p_wen_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wen_q && !supply_low_i) |=> wen_q);
  p_clr_reads_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_rdata_o[CLR_BIT]);
  p_cfg_locked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_o && !supply_low_i) |=> $stable(cfg_rdata_o));
  p_off_no_ovf_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wen_q |-> !ovf);
endmodule

// File: tb/tb_supply_wdt_reset.sv
module tb_supply_wdt_reset;
  localparam int HOLD = 144;
  localparam int TICK = 8;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       supply_low_i = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [4:0] cfg_wdata_i = '0;
  logic [4:0] cfg_rdata_o;
  logic       rst_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  supply_wdt_reset #(.HOLD_CYC(HOLD), .TICK_CYC(TICK)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .supply_low_i(supply_low_i),
    .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
    .cfg_rdata_o(cfg_rdata_o), .rst_o(rst_o)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one-cycle write; starts and ends at a negedge
  task automatic wr(logic [4:0] d);
    cfg_we_i = 1'b1; cfg_wdata_i = d;
    @(posedge clk); @(negedge clk);
    cfg_we_i = 1'b0; cfg_wdata_i = '0;
  endtask

  // rising edges until rst_o seen high (cap)
  task automatic edges_to_rise(output int k, input int cap);
    k = 0;
    do begin @(posedge clk); k++; @(negedge clk); end
    while (!rst_o && k < cap);
  endtask

  // cycles rst_o stays high, from a negedge where it is high
  task automatic high_len(output int k);
    k = 0;
    while (rst_o && k < 10000) begin k++; @(posedge clk); @(negedge clk); end
  endtask

  task automatic supply_pulse();
    supply_low_i = 1'b1;
    repeat (3) @(negedge clk);
    supply_low_i = 1'b0;
  endtask

  initial begin
    int k;
    int n;
    @(negedge clk);
    check("R1 por", int'(rst_o), 1);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R3: release stretch after power-on; edges after rst_ni rise
    k = 0;
    while (rst_o && k < 1000) begin @(posedge clk); k++; @(negedge clk); end
    check("R3 por stretch", k, HOLD);
    check("R3 rdata reset", int'(cfg_rdata_o), 0);
    // R9: disabled watchdog stays quiet
    edges_to_rise(k, 300);
    check("R9 no reset when off", int'(rst_o), 0);

    // R1 asynchronous assertion
    #2 supply_low_i = 1'b1; #1;
    check("R1 async", int'(rst_o), 1);
    @(negedge clk); supply_low_i = 1'b0;
    // R2: stretch after supply recovers
    high_len(k);
    check("R2 lvr stretch", k, HOLD);

    // sweep all interval codes: R4, R5, R6
    for (int s = 0; s < 8; s++) begin
      supply_pulse();
      high_len(k);
      check("R6 cleared by lvr", int'(cfg_rdata_o), 0);
      n = (s == 0) ? 8 : s;
      wr(5'(8 + s));
      check("R4 readback", int'(cfg_rdata_o), 8 + s);
      edges_to_rise(k, 200);
      check("R4 interval", k, n * TICK);
      high_len(k);
      check("R5 ovf stretch", k, HOLD);
      check("R6 en kept", int'(cfg_rdata_o), 8 + s);
      edges_to_rise(k, 200);
      check("R4 interval after wdt reset", k, n * TICK);
      high_len(k);
    end

    // R6: writing 0 to enable has no effect
    supply_pulse(); high_len(k);
    wr(5'b01001);
    wr(5'b00001);
    check("R6 enable set-only", int'(cfg_rdata_o), 9);
    // R7: periodic restarts hold off reset
    for (int i = 0; i < 12; i++) begin
      repeat (4) @(negedge clk);
      wr(5'b10001);
    end
    check("R7 restart holds off", int'(rst_o), 0);
    check("R7 reads zero", int'(cfg_rdata_o[4]), 0);
    // R7: restart on the overflow edge wins
    wr(5'b10001);               // restart at edge E0
    repeat (TICK - 1) @(posedge clk);
    @(negedge clk);
    wr(5'b10001);               // takes effect on E_TICK, the overflow edge
    check("R7 same-edge restart", int'(rst_o), 0);
    edges_to_rise(k, 200);
    check("R7 next interval", k, TICK);
    // R8: writes during reset ignored
    cfg_we_i = 1'b1; cfg_wdata_i = 5'b01010;
    high_len(k);
    cfg_we_i = 1'b0; cfg_wdata_i = '0;
    check("R8 write locked", int'(cfg_rdata_o), 9);
    supply_pulse();
    cfg_we_i = 1'b1; cfg_wdata_i = 5'b01011;
    high_len(k);
    cfg_we_i = 1'b0; cfg_wdata_i = '0;
    check("R8 lvr-time write locked", int'(cfg_rdata_o), 0);
    edges_to_rise(k, 200);
    check("R8 R9 stays off", int'(rst_o), 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule